// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. The address splits into three fields: a 10-bit directory index in bits [31:22], a 10-bit table index in bits [21:12] and a 12-bit page offset in bits [11:0]. The offset passes through untranslated because pages are 4 KB. The walker first reads a directory entry from the table page named by the table-base input. It then reads a leaf entry from the page that the directory entry points to. The physical address is the leaf frame number joined to the offset. Each table takes exactly one 4 KB page.

Every entry is 32 bits. The frame number is in bits [31:12], the writable flag is in bit 1 and the valid flag is in bit 0. Bits [11:2] are ignored. The walker checks both flags at each level. A missing entry or a store to a protected page ends the walk with a fault, so that system software can repair the mapping and retry. A directory index at or above the table-length input ends the walk at once, with no memory traffic. Memory is reached through a request/response port, and only one read is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: A walk that passes every check ends with `done` and `fault` low. `paddr` equals the leaf entry's bits [31:12] joined to the request's bits [11:0].
- R2: The first read goes to {`tbl_base_frame`, directory index, 2'b00}. The second read goes to {directory-entry frame, table index, 2'b00}.
- R3: A request whose directory index is greater than or equal to `tbl_len` faults with `fault_level`=0 and `fault_cause`=3. It issues no memory read, and `done` rises on the cycle after acceptance.
- R4: An entry with bit 0 clear faults with `fault_cause`=1. `fault_level` is 0 for the directory entry and 1 for the leaf entry, and the walk stops after that read.
- R5: A write request that meets an entry with bit 1 clear, at either level, faults with `fault_cause`=2 at that level. A read request to the same page succeeds.
- R6: `mem_req` is high for one cycle per read. No new read is issued until `mem_rsp_valid` has returned the previous one.
- R7: `req_ready` is high only while the walker is idle. Requests offered during a walk are ignored and do not change its result.
- R8: After a synchronous active-high reset, `req_ready` is 1 and `done`, `fault` and `mem_req` are 0.
- R9: When an entry is both invalid and read-only, a write request reports `fault_cause`=1 (invalid), not write-protect.
- R10: `done` is high for exactly one cycle per walk. `req_ready` returns on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base_frame | input | 20 | Frame number of the directory page |
| tbl_len | input | 11 | Number of usable directory entries (0 to 1024) |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = store access, 0 = load access |
| req_ready | output | 1 | Walker idle and accepting a request |
| mem_req | output | 1 | One-cycle read strobe to table memory |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle walk completion pulse |
| paddr | output | 32 | Translated physical address (when done and no fault) |
| fault | output | 1 | Walk ended in a page fault (with done) |
| fault_level | output | 1 | Level that faulted: 0 directory, 1 leaf |
| fault_cause | output | 2 | 1 invalid, 2 write-protect, 3 beyond length |

## Verification
A corrupted frame register shows up as a wrong `mem_addr` on the second read, one cycle after the directory response. It also shows up in `paddr` when `done` pulses. A sequencer stuck in a wait state shows `req_ready` held low and no `done`. A sequencer that skips a state shows a read count other than the expected 0, 1 or 2. A mixed-up level or cause register is visible only in the single `done` cycle. The stimulus therefore covers each fault cause at both levels where it can occur, and uses memory latencies of zero to two cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int FRAME_W   = VA_W - OFF_W;
    localparam int PTE_W     = 32;
    localparam int LEN_W     = IDX_W + 1;
    localparam int PTE_V_BIT = 0;
    localparam int PTE_W_BIT = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_DIR,
        S_WT_DIR,
        S_RD_LEAF,
        S_WT_LEAF,
        S_DONE,
        S_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_WPROT   = 2'd2,
        CAUSE_BOUND   = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic [IDX_W-1:0] dir;
        logic [IDX_W-1:0] tbl;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    // Byte address of one 32-bit entry inside a table page
    function automatic logic [VA_W-1:0] entry_addr(
        input logic [FRAME_W-1:0] frame,
        input logic [IDX_W-1:0]   idx
    );
        return {frame, idx, 2'b00};
    endfunction

endpackage

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
(
    input  logic         valid_bit,
    input  logic         writable_bit,
    input  logic         is_write,
    output logic         pass,
    output fault_cause_e cause
);

    // Invalid has priority over write-protect (R9)
    always_comb begin
        if (!valid_bit)
            cause = CAUSE_INVALID;
        else if (is_write && !writable_bit)
            cause = CAUSE_WPROT;
        else
            cause = CAUSE_NONE;
        pass = (cause == CAUSE_NONE);
    end

endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] tbl_base_frame,
    input  logic [LEN_W-1:0]   tbl_len,
    input  logic               req_valid,
    input  vaddr_t             req_vaddr,
    input  logic               req_write,
    output logic               req_ready,
    output logic               mem_req,
    output logic [VA_W-1:0]    mem_addr,
    input  logic               mem_rsp_valid,
    input  logic [FRAME_W-1:0] rsp_frame,
    input  logic               chk_pass,
    input  fault_cause_e       chk_cause,
    output logic               acc_write,
    output logic               done,
    output logic [VA_W-1:0]    paddr,
    output logic               fault,
    output logic               fault_level,
    output fault_cause_e       fault_cause
);

    walk_state_e        state_q;
    vaddr_t             va_q;
    logic               wr_q;
    logic [FRAME_W-1:0] frame_q;
    logic               lvl_q;
    fault_cause_e       cause_q;
    logic               beyond_len;

    assign beyond_len = ({1'b0, req_vaddr.dir} >= tbl_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            frame_q <= '0;
            lvl_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q <= req_vaddr;
                        wr_q <= req_write;
                        if (beyond_len) begin
                            lvl_q   <= 1'b0;
                            cause_q <= CAUSE_BOUND;
                            state_q <= S_FAULT;
                        end else begin
                            frame_q <= tbl_base_frame;
                            state_q <= S_RD_DIR;
                        end
                    end
                end
                S_RD_DIR: state_q <= S_WT_DIR;
                S_WT_DIR: begin
                    if (mem_rsp_valid) begin
                        if (chk_pass) begin
                            frame_q <= rsp_frame;
                            state_q <= S_RD_LEAF;
                        end else begin
                            lvl_q   <= 1'b0;
                            cause_q <= chk_cause;
                            state_q <= S_FAULT;
                        end
                    end
                end
                S_RD_LEAF: state_q <= S_WT_LEAF;
                S_WT_LEAF: begin
                    if (mem_rsp_valid) begin
                        if (chk_pass) begin
                            frame_q <= rsp_frame;
                            state_q <= S_DONE;
                        end else begin
                            lvl_q   <= 1'b1;
                            cause_q <= chk_cause;
                            state_q <= S_FAULT;
                        end
                    end
                end
                S_DONE:  state_q <= S_IDLE;
                S_FAULT: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready   = (state_q == S_IDLE);
        mem_req     = (state_q == S_RD_DIR) || (state_q == S_RD_LEAF);
        mem_addr    = entry_addr(frame_q, (state_q == S_RD_DIR) ? va_q.dir : va_q.tbl);
        acc_write   = wr_q;
        done        = (state_q == S_DONE) || (state_q == S_FAULT);
        fault       = (state_q == S_FAULT);
        paddr       = (state_q == S_DONE) ? {frame_q, va_q.off} : '0;
        fault_level = (state_q == S_FAULT) ? lvl_q : 1'b0;
        fault_cause = (state_q == S_FAULT) ? cause_q : CAUSE_NONE;
    end

    // R6: every read strobe lasts one cycle
    p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R6: no new read while the directory response is outstanding
    p_wait_blocks_read_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WT_DIR && !mem_rsp_valid) |=> !mem_req);

    // R3: out-of-range index faults next cycle without touching memory
    p_bound_fault_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && beyond_len) |=>
            (fault && fault_cause == CAUSE_BOUND && !fault_level && !mem_req));

    // R10: completion is a single-cycle pulse followed by idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    // R4: a reported fault always carries a cause
    p_fault_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fault_cause != CAUSE_NONE && done));

    // R5: write-protect faults only arise from store accesses
    p_wprot_on_store_r5: assert property (@(posedge clk) disable iff (rst)
        (fault && fault_cause == CAUSE_WPROT) |-> acc_write);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] tbl_base_frame,
    input  logic [LEN_W-1:0]   tbl_len,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    output logic               req_ready,
    output logic               mem_req,
    output logic [VA_W-1:0]    mem_addr,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_data,
    output logic               done,
    output logic [VA_W-1:0]    paddr,
    output logic               fault,
    output logic               fault_level,
    output logic [1:0]         fault_cause
);

    logic         chk_pass;
    fault_cause_e chk_cause;
    fault_cause_e cause_e;
    logic         acc_write;
    logic         unused_rsvd;

    assign unused_rsvd = ^mem_rsp_data[OFF_W-1:PTE_W_BIT+1];

    ptw_entry_check u_chk (
        .valid_bit    (mem_rsp_data[PTE_V_BIT]),
        .writable_bit (mem_rsp_data[PTE_W_BIT]),
        .is_write     (acc_write),
        .pass         (chk_pass),
        .cause        (chk_cause)
    );

    ptw_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .tbl_base_frame (tbl_base_frame),
        .tbl_len        (tbl_len),
        .req_valid      (req_valid),
        .req_vaddr      (vaddr_t'(req_vaddr)),
        .req_write      (req_write),
        .req_ready      (req_ready),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .rsp_frame      (mem_rsp_data[PTE_W-1:OFF_W]),
        .chk_pass       (chk_pass),
        .chk_cause      (chk_cause),
        .acc_write      (acc_write),
        .done           (done),
        .paddr          (paddr),
        .fault          (fault),
        .fault_level    (fault_level),
        .fault_cause    (cause_e)
    );

    assign fault_cause = cause_e;

endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        ef;
        logic        el;
        logic [1:0]  ec;
        logic [31:0] ep;
        logic [1:0]  nr;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'h00000123, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0ABCD123, 2'd2},
        '{32'h00000123, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0ABCD123, 2'd2},
        '{32'h00005456, 1'b0, 1'b0, 1'b0, 2'd0, 32'h01234456, 2'd2},
        '{32'h00005456, 1'b1, 1'b1, 1'b1, 2'd2, 32'h00000000, 2'd2},
        '{32'h00007000, 1'b0, 1'b1, 1'b1, 2'd1, 32'h00000000, 2'd2},
        '{32'h00400000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h05555000, 2'd2},
        '{32'h00400010, 1'b1, 1'b1, 1'b0, 2'd2, 32'h00000000, 2'd1},
        '{32'h00800000, 1'b0, 1'b1, 1'b0, 2'd1, 32'h00000000, 2'd1},
        '{32'h00800000, 1'b1, 1'b1, 1'b0, 2'd1, 32'h00000000, 2'd1},
        '{32'h00FFFFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'hFFFFFFFF, 2'd2},
        '{32'h01000000, 1'b0, 1'b1, 1'b0, 2'd3, 32'h00000000, 2'd0},
        '{32'hFFC00000, 1'b1, 1'b1, 1'b0, 2'd3, 32'h00000000, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] tbl_base_frame = 20'h00010;
    logic [10:0] tbl_len = 11'd4;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done;
    logic [31:0] paddr;
    logic        fault;
    logic        fault_level;
    logic [1:0]  fault_cause;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker u0 (
        .clk            (clk),
        .rst            (rst),
        .tbl_base_frame (tbl_base_frame),
        .tbl_len        (tbl_len),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .req_write      (req_write),
        .req_ready      (req_ready),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .done           (done),
        .paddr          (paddr),
        .fault          (fault),
        .fault_level    (fault_level),
        .fault_cause    (fault_cause)
    );

    // Behavioural table memory
    function automatic logic [31:0] mem_lookup(input logic [31:0] a);
        case (a)
            32'h00010000: return 32'h00020003;
            32'h00010004: return 32'h00021001;
            32'h00010008: return 32'h00022000;
            32'h0001000C: return 32'h00023003;
            32'h00020000: return 32'h0ABCD003;
            32'h00020014: return 32'h01234001;
            32'h00021000: return 32'h05555003;
            32'h00023FFC: return 32'hFFFFF003;
            default:      return 32'h00000000;
        endcase
    endfunction

    int          lat = 0;
    int          cnt = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          rd_cnt = 0;
    int          overlap = 0;
    logic [31:0] a_prev = '0;
    logic [31:0] a_last = '0;

    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
    end

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst) begin
            pend <= 1'b0;
        end else if (mem_req) begin
            if (pend) overlap <= overlap + 1;
            pend      <= 1'b1;
            cnt       <= lat;
            pend_addr <= mem_addr;
            rd_cnt    <= rd_cnt + 1;
            a_prev    <= a_last;
            a_last    <= mem_addr;
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_lookup(pend_addr);
                pend          <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    logic        g_done;
    logic        g_fault;
    logic        g_lvl;
    logic [1:0]  g_cause;
    logic [31:0] g_paddr;
    int          g_reads;

    task automatic do_walk(input logic [31:0] va, input logic wr, input logic hold_busy);
        int base;
        @(negedge clk);
        for (int k = 0; k < 50 && !req_ready; k++) @(negedge clk);
        base      = rd_cnt;
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        @(negedge clk);
        if (hold_busy) begin
            req_vaddr = 32'h00400000;
            req_write = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        for (int k = 0; k < 100 && !done; k++) @(negedge clk);
        g_done  = done;
        g_fault = fault;
        g_lvl   = fault_level;
        g_cause = fault_cause;
        g_paddr = paddr;
        req_valid = 1'b0;
        @(negedge clk);
        g_reads = rd_cnt - base;
    endtask

    function automatic string tag_of(input vec_t v);
        if (!v.ef) return "R1";
        case (v.ec)
            2'd1:    return (v.wr && v.va[31:22] == 10'd2) ? "R9" : "R4";
            2'd2:    return "R5";
            default: return "R3";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R8 done", {31'd0, done}, 32'd0);
        chk("R8 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R8 fault", {31'd0, fault}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            lat = i % 3;
            do_walk(VECS[i].va, VECS[i].wr, 1'b0);
            chk({tag_of(VECS[i]), " done"}, {31'd0, g_done}, 32'd1);
            chk({tag_of(VECS[i]), " fault"}, {31'd0, g_fault}, {31'd0, VECS[i].ef});
            chk({tag_of(VECS[i]), " reads"}, g_reads, {30'd0, VECS[i].nr});
            if (VECS[i].ef) begin
                chk({tag_of(VECS[i]), " level"}, {31'd0, g_lvl}, {31'd0, VECS[i].el});
                chk({tag_of(VECS[i]), " cause"}, {30'd0, g_cause}, {30'd0, VECS[i].ec});
            end else begin
                chk({tag_of(VECS[i]), " paddr"}, g_paddr, VECS[i].ep);
            end
            if (i == 9) begin
                chk("R2 dir entry address", a_prev, 32'h0001000C);
                chk("R2 leaf entry address", a_last, 32'h00023FFC);
            end
        end

        // R3: zero length rejects index 0
        tbl_len = 11'd0;
        do_walk(32'h00000123, 1'b0, 1'b0);
        chk("R3 len0 cause", {30'd0, g_cause}, 32'd3);
        chk("R3 len0 reads", g_reads, 32'd0);

        // R3: full length admits index 1023, which then reads an invalid entry
        tbl_len = 11'd1024;
        lat = 1;
        do_walk(32'hFFC00000, 1'b0, 1'b0);
        chk("R3 len1024 cause", {30'd0, g_cause}, 32'd1);
        chk("R3 len1024 reads", g_reads, 32'd1);
        chk("R2 last dir address", a_last, 32'h00010FFC);

        // R7: request held during a walk is ignored
        tbl_len = 11'd4;
        lat = 3;
        fork
            do_walk(32'h00000123, 1'b0, 1'b1);
            begin
                repeat (4) @(negedge clk);
                chk("R7 busy not ready", {31'd0, req_ready}, 32'd0);
            end
        join
        chk("R7 result kept", g_paddr, 32'h0ABCD123);
        chk("R7 reads", g_reads, 32'd2);
        chk("R10 ready after done", {31'd0, req_ready}, 32'd1);
        chk("R10 done single cycle", {31'd0, done}, 32'd0);

        // R6: never two reads in flight
        chk("R6 overlap", overlap, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule